// File: doc/BRIEF.md
# ADC Sample Output Formatter

This block sits between a 14-bit converter core and the output pins. Every sample clock it takes one offset-binary sample and an overrange flag, re-codes the sample into the selected number format, and delays it through a fixed pipeline. It then presents the sample in one of two ways. In single-rate mode the whole word appears on a parallel bus. In double-data-rate mode the word is split into bit pairs: seven shared lanes carry the even bits in one half of the clock period and the odd bits in the other half.

A data clock is driven with the data so that the receiving logic can latch it. An active-low enable blanks every data and overrange output without stopping the pipeline. The coding and the output mode come either from two register fields or, when strap control is selected, from two strap pins. The settings are captured together with each sample, so every word carries exactly one coding and one mode.

Top module: `adc_out_fmt`

## Requirements
- R1: Coding codes are 0 for offset binary (the sample unchanged), 1 for twos complement (the sample with its MSB inverted) and 2 for Gray (the sample XOR the sample shifted right by one). Code 3 is treated as offset binary.
- R2: In single-rate mode, a sample captured at rising edge n drives `sdr_data` and `sdr_ovr` from just after rising edge n+11 until rising edge n+12. This is twelve register stages.
- R3: In double-rate mode, the same sample reaches the lanes half a cycle later than in R2. It is held from the falling edge after rising edge n+11 to the next falling edge. Lane i carries bit 2i while `dclk` is high and bit 2i+1 while `dclk` is low, and `dclk` is the inverted clock.
- R4: When the word at the output is single-rate, `dclk` equals the clock and the lanes and `ddr_ovr` are 0. When the word at the output is double-rate, `sdr_data` and `sdr_ovr` are 0.
- R5: The overrange flag travels with its own sample. It appears on `sdr_ovr` in single-rate mode. In double-rate mode it appears on its own lane `ddr_ovr`, held for both halves.
- R6: While `oe_n` is 1, `sdr_data`, `sdr_ovr`, `ddr_lane` and `ddr_ovr` are 0 within the same cycle. The pipeline keeps running, so after re-enable the outputs show the word that is due at that time.
- R7: With `strap_en` at 1, `strap_fmt` selects the coding (0 offset binary, 1 twos complement) and `strap_ddr` selects the mode, and `reg_fmt` and `reg_ddr` are ignored.
- R8: The coding and the mode are sampled on the same edge as the sample and apply to that sample only. A change between two consecutive samples splits cleanly between the two words.
- R9: During and right after reset, all data and overrange outputs are 0 and `dclk` follows the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_data | input | 14 | Converter sample, offset binary |
| smp_ovr | input | 1 | Overrange flag of the sample |
| oe_n | input | 1 | Output enable, active low |
| strap_en | input | 1 | 1 selects strap pins over registers |
| strap_fmt | input | 1 | Strap coding select: 0 offset binary, 1 twos complement |
| strap_ddr | input | 1 | Strap mode select: 1 double-rate |
| reg_fmt | input | 2 | Register coding code (see R1) |
| reg_ddr | input | 1 | Register mode select: 1 double-rate |
| sdr_data | output | 14 | Single-rate parallel word |
| sdr_ovr | output | 1 | Single-rate overrange |
| ddr_lane | output | 7 | Double-rate bit-pair lanes |
| ddr_ovr | output | 1 | Double-rate overrange lane |
| dclk | output | 1 | Data clock for the receiver |

## Verification
A sample driven just after rising edge e is captured at edge e+1. The bench therefore expects it on `sdr_data` 3 ns after edge e+12. It expects the even half on the lanes 7 ns after that edge, while the clock is low and `dclk` is high, and the odd half 3 ns after edge e+13. Each driven sample is logged by edge number together with its effective coding, mode and overrange. Every period the bench compares the single-rate bus against the entry twelve edges back. It compares the even lane half against the same entry and the odd lane half against the entry thirteen edges back. Enable and blanking act combinationally, so they are checked in the same period in which `oe_n` changes.

// File: rtl/adc_out_fmt_pkg.sv
// Package: shared coding type for the sample output formatter.
// Assumes: the converter delivers offset-binary samples.
package adc_out_fmt_pkg;

    localparam int SMP_W = 14;

    typedef enum logic [1:0] {
        FMT_OFFSET = 2'd0,
        FMT_TWOS   = 2'd1,
        FMT_GRAY   = 2'd2,
        FMT_SPARE  = 2'd3
    } fmt_e;

endpackage

// File: rtl/fmt_encoder.sv
// fmt_encoder: combinational re-coding of one offset-binary sample.
// Assumes: the spare code behaves as offset binary.
module fmt_encoder
    import adc_out_fmt_pkg::*;
#(
    parameter int DW = SMP_W
) (
    input  logic [DW-1:0] raw,
    input  fmt_e          fmt,
    output logic [DW-1:0] coded
);

    // Select the output coding of the sample.
    always_comb begin
        case (fmt)
            FMT_TWOS: coded = {~raw[DW-1], raw[DW-2:0]};
            FMT_GRAY: coded = raw ^ (raw >> 1);
            default:  coded = raw;
        endcase
    end

endmodule

// File: rtl/align_pipe.sv
// align_pipe: fixed-depth register delay line for a packed sample record.
// Assumes: LAT >= 1; reset clears every stage to zero.
module align_pipe #(
    parameter int W   = 16,
    parameter int LAT = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage [LAT];

    // First stage captures the incoming record.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= din;
    end

    generate
        for (genvar g = 1; g < LAT; g++) begin : g_stage
            // Shift the record one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
        end
    endgenerate

    assign dout = stage[LAT-1];

endmodule

// File: rtl/ddr_lane_mux.sv
// ddr_lane_mux: retimes the delayed word by half a cycle and folds bit
// pairs onto shared lanes; also drives the data clock.
// Assumes: DW is even; even bits go out while dclk is high.
module ddr_lane_mux #(
    parameter int DW = 14,
    localparam int LANES = DW / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    word_in,
    input  logic             ovr_in,
    input  logic             ddr_in,
    output logic [LANES-1:0] lane,
    output logic             lane_ovr,
    output logic             dclk
);

    logic [DW-1:0]    half_word;
    logic             half_ovr;
    logic             half_ddr;
    logic [LANES-1:0] even_bits;
    logic [LANES-1:0] odd_bits;

    // Falling-edge capture adds the half-cycle of double-rate latency.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            half_word <= '0;
            half_ovr  <= 1'b0;
            half_ddr  <= 1'b0;
        end else begin
            half_word <= word_in;
            half_ovr  <= ovr_in;
            half_ddr  <= ddr_in;
        end
    end

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_pair
            assign even_bits[i] = half_word[2*i];
            assign odd_bits[i]  = half_word[2*i+1];
        end
    endgenerate

    // Data clock: inverted clock for double-rate words, clock otherwise.
    always_comb dclk = half_ddr ? ~clk : clk;

    // Lanes carry the even half while dclk is high, odd half while low.
    always_comb begin
        if (!half_ddr) begin
            lane     = '0;
            lane_ovr = 1'b0;
        end else begin
            lane     = dclk ? even_bits : odd_bits;
            lane_ovr = half_ovr;
        end
    end

endmodule

// File: rtl/adc_out_fmt.sv
// adc_out_fmt: codes each sample, aligns it through a fixed pipeline and
// presents it single-rate or double-rate, with data clock and blanking.
// Assumes: smp_data is offset binary, one sample per rising clock edge.
module adc_out_fmt
    import adc_out_fmt_pkg::*;
#(
    parameter int DW  = SMP_W,
    parameter int LAT = 12,
    localparam int LANES = DW / 2,
    localparam int RW    = DW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    smp_data,
    input  logic             smp_ovr,
    input  logic             oe_n,
    input  logic             strap_en,
    input  logic             strap_fmt,
    input  logic             strap_ddr,
    input  logic [1:0]       reg_fmt,
    input  logic             reg_ddr,
    output logic [DW-1:0]    sdr_data,
    output logic             sdr_ovr,
    output logic [LANES-1:0] ddr_lane,
    output logic             ddr_ovr,
    output logic             dclk
);

    fmt_e             sel_fmt;
    logic             sel_ddr;
    logic [DW-1:0]    coded;
    logic [RW-1:0]    rec_in;
    logic [RW-1:0]    rec_out;
    logic [DW-1:0]    out_word;
    logic             out_ovr;
    logic             out_ddr;
    logic [LANES-1:0] lane_raw;
    logic             lane_ovr_raw;

    // Choose configuration source: strap pins or register fields.
    always_comb begin
        if (strap_en) begin
            sel_fmt = strap_fmt ? FMT_TWOS : FMT_OFFSET;
            sel_ddr = strap_ddr;
        end else begin
            sel_fmt = fmt_e'(reg_fmt);
            sel_ddr = reg_ddr;
        end
    end

    fmt_encoder #(.DW(DW)) u_enc (
        .raw   (smp_data),
        .fmt   (sel_fmt),
        .coded (coded)
    );

    assign rec_in = {sel_ddr, smp_ovr, coded};

    align_pipe #(.W(RW), .LAT(LAT)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rec_in),
        .dout  (rec_out)
    );

    assign out_word = rec_out[DW-1:0];
    assign out_ovr  = rec_out[DW];
    assign out_ddr  = rec_out[DW+1];

    ddr_lane_mux #(.DW(DW)) u_ddr (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_in  (out_word),
        .ovr_in   (out_ovr),
        .ddr_in   (out_ddr),
        .lane     (lane_raw),
        .lane_ovr (lane_ovr_raw),
        .dclk     (dclk)
    );

    // Single-rate bus shows only single-rate words, blanked by enable.
    always_comb begin
        if (oe_n || out_ddr) begin
            sdr_data = '0;
            sdr_ovr  = 1'b0;
        end else begin
            sdr_data = out_word;
            sdr_ovr  = out_ovr;
        end
    end

    // Double-rate lanes blanked by enable.
    always_comb begin
        ddr_lane = oe_n ? '0 : lane_raw;
        ddr_ovr  = oe_n ? 1'b0 : lane_ovr_raw;
    end

endmodule

// File: rtl/adc_out_fmt_chk.sv
// adc_out_fmt_chk: assertion checker bound to adc_out_fmt. Keeps its own
// history of raw inputs and effective settings and compares the outputs.
// Assumes: LAT stays small enough for a plain shift history.
module adc_out_fmt_chk #(
    parameter int DW  = 14,
    parameter int LAT = 12,
    localparam int LANES = DW / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    smp_data,
    input  logic             smp_ovr,
    input  logic             oe_n,
    input  logic             strap_en,
    input  logic             strap_fmt,
    input  logic             strap_ddr,
    input  logic [1:0]       reg_fmt,
    input  logic             reg_ddr,
    input  logic [DW-1:0]    sdr_data,
    input  logic             sdr_ovr,
    input  logic [LANES-1:0] ddr_lane,
    input  logic             ddr_ovr,
    input  logic             dclk
);

    logic [DW-1:0] h_raw [LAT];
    logic [1:0]    h_fmt [LAT];
    logic          h_ovr [LAT];
    logic          h_ddr [LAT];
    logic [1:0]    eff_fmt;
    logic          eff_ddr;
    logic [DW-1:0] exp_word;
    logic [LANES-1:0] exp_even;

    // Effective settings seen at the input edge.
    always_comb begin
        eff_fmt = strap_en ? {1'b0, strap_fmt} : reg_fmt;
        eff_ddr = strap_en ? strap_ddr : reg_ddr;
    end

    // History of what entered the block, one entry per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                h_raw[i] <= '0;
                h_fmt[i] <= '0;
                h_ovr[i] <= 1'b0;
                h_ddr[i] <= 1'b0;
            end
        end else begin
            h_raw[0] <= smp_data;
            h_fmt[0] <= eff_fmt;
            h_ovr[0] <= smp_ovr;
            h_ddr[0] <= eff_ddr;
            for (int i = 1; i < LAT; i++) begin
                h_raw[i] <= h_raw[i-1];
                h_fmt[i] <= h_fmt[i-1];
                h_ovr[i] <= h_ovr[i-1];
                h_ddr[i] <= h_ddr[i-1];
            end
        end
    end

    // Expected coded word of the oldest history entry.
    always_comb begin
        exp_word = h_raw[LAT-1];
        if (h_fmt[LAT-1] == 2'd1)
            exp_word[DW-1] = ~h_raw[LAT-1][DW-1];
        else if (h_fmt[LAT-1] == 2'd2)
            exp_word = h_raw[LAT-1] ^ {1'b0, h_raw[LAT-1][DW-1:1]};
        for (int i = 0; i < LANES; i++) exp_even[i] = exp_word[2*i];
    end

    AST_SDR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !h_ddr[LAT-1]) |-> (sdr_data == exp_word)) // R2
        else $error("AST_SDR_WORD");

    AST_SDR_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !h_ddr[LAT-1]) |-> (sdr_ovr == h_ovr[LAT-1])) // R5
        else $error("AST_SDR_OVR");

    AST_DDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && h_ddr[LAT-1]) |-> (dclk && ddr_lane == exp_even && ddr_ovr == h_ovr[LAT-1])) // R3
        else $error("AST_DDR_EVEN");

    AST_SDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        h_ddr[LAT-1] |-> (sdr_data == '0 && !sdr_ovr)) // R4
        else $error("AST_SDR_QUIET");

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (sdr_data == '0 && !sdr_ovr && ddr_lane == '0 && !ddr_ovr)) // R6
        else $error("AST_OE_QUIET");

endmodule

bind adc_out_fmt adc_out_fmt_chk #(.DW(DW), .LAT(LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_data  (smp_data),
    .smp_ovr   (smp_ovr),
    .oe_n      (oe_n),
    .strap_en  (strap_en),
    .strap_fmt (strap_fmt),
    .strap_ddr (strap_ddr),
    .reg_fmt   (reg_fmt),
    .reg_ddr   (reg_ddr),
    .sdr_data  (sdr_data),
    .sdr_ovr   (sdr_ovr),
    .ddr_lane  (ddr_lane),
    .ddr_ovr   (ddr_ovr),
    .dclk      (dclk)
);

// File: tb/tb_adc_out_fmt.sv
// tb_adc_out_fmt: directed bench; logs each driven sample by edge number
// and checks outputs twelve and thirteen edges later.
module tb_adc_out_fmt;

    localparam int LAT = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] smp_data = '0;
    logic        smp_ovr = 1'b0;
    logic        oe_n = 1'b0;
    logic        strap_en = 1'b0;
    logic        strap_fmt = 1'b0;
    logic        strap_ddr = 1'b0;
    logic [1:0]  reg_fmt = 2'd0;
    logic        reg_ddr = 1'b0;
    logic [13:0] sdr_data;
    logic        sdr_ovr;
    logic [6:0]  ddr_lane;
    logic        ddr_ovr;
    logic        dclk;

    // Settings the next tick applies.
    logic        c_oe_n = 1'b0, c_sen = 1'b0, c_sfmt = 1'b0, c_sddr = 1'b0, c_rddr = 1'b0;
    logic [1:0]  c_rfmt = 2'd0;

    logic [13:0] h_word [4096];
    logic        h_ovr  [4096];
    logic        h_ddr  [4096];
    int          ecnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    adc_out_fmt dut (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_ovr(smp_ovr),
        .oe_n(oe_n), .strap_en(strap_en), .strap_fmt(strap_fmt),
        .strap_ddr(strap_ddr), .reg_fmt(reg_fmt), .reg_ddr(reg_ddr),
        .sdr_data(sdr_data), .sdr_ovr(sdr_ovr), .ddr_lane(ddr_lane),
        .ddr_ovr(ddr_ovr), .dclk(dclk)
    );

    function automatic logic [13:0] enc(input logic [13:0] r, input int f);
        if (f == 1) return r ^ 14'h2000;
        if (f == 2) return r ^ (r >> 1);
        return r;
    endfunction

    function automatic logic [6:0] half(input logic [13:0] w, input int odd);
        logic [6:0] v;
        for (int i = 0; i < 7; i++) v[i] = w[2*i+odd];
        return v;
    endfunction

    task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tg, act, exp);
        end
    endtask

    // One sample period: drive, log, then check both clock phases.
    task automatic tick(input string tg, input logic [13:0] d, input logic o);
        int i, j, f;
        logic ed;
        @(posedge clk);
        ecnt++;
        #1;
        smp_data = d; smp_ovr = o; oe_n = c_oe_n; strap_en = c_sen;
        strap_fmt = c_sfmt; strap_ddr = c_sddr; reg_fmt = c_rfmt; reg_ddr = c_rddr;
        f  = c_sen ? int'(c_sfmt) : (c_rfmt == 2'd3 ? 0 : int'(c_rfmt));
        ed = c_sen ? c_sddr : c_rddr;
        h_word[ecnt] = enc(d, f); h_ovr[ecnt] = o; h_ddr[ecnt] = ed;
        i = (ecnt - LAT < 0) ? 0 : ecnt - LAT;
        j = (ecnt - 1 - LAT < 0) ? 0 : ecnt - 1 - LAT;
        #2; // clk high: single-rate word i, odd half of word j
        chk({tg, "/R2 sdr_data"}, 32'(sdr_data), (oe_n || h_ddr[i]) ? 32'd0 : 32'(h_word[i]));
        chk({tg, "/R5 sdr_ovr"}, 32'(sdr_ovr), (oe_n || h_ddr[i]) ? 32'd0 : 32'(h_ovr[i]));
        chk({tg, "/R3 odd lanes"}, 32'(ddr_lane), (oe_n || !h_ddr[j]) ? 32'd0 : 32'(half(h_word[j], 1)));
        chk({tg, "/R5 ddr_ovr odd"}, 32'(ddr_ovr), (oe_n || !h_ddr[j]) ? 32'd0 : 32'(h_ovr[j]));
        chk({tg, "/R4 dclk high phase"}, 32'(dclk), h_ddr[j] ? 32'd0 : 32'd1);
        #4; // clk low: even half of word i
        chk({tg, "/R3 even lanes"}, 32'(ddr_lane), (oe_n || !h_ddr[i]) ? 32'd0 : 32'(half(h_word[i], 0)));
        chk({tg, "/R5 ddr_ovr even"}, 32'(ddr_ovr), (oe_n || !h_ddr[i]) ? 32'd0 : 32'(h_ovr[i]));
        chk({tg, "/R4 dclk low phase"}, 32'(dclk), h_ddr[i] ? 32'd1 : 32'd0);
    endtask

    task automatic run(input string tg, input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            logic [13:0] d;
            d = 14'((k * 1237 + seed * 977) & 16'h3fff);
            if (k == 0) d = 14'h0000;
            if (k == 1) d = 14'h3fff;
            if (k == 2) d = 14'h2000;
            tick(tg, d, 1'(((k * 3) + seed) % 5 == 0));
        end
    endtask

    task automatic t_reset;
        // R9: outputs quiet and dclk follows clk in reset
        repeat (3) @(posedge clk);
        #3;
        chk("R9 sdr_data", 32'(sdr_data), 0);
        chk("R9 ddr_lane", 32'(ddr_lane), 0);
        chk("R9 ovr", 32'({sdr_ovr, ddr_ovr}), 0);
        chk("R9 dclk high", 32'(dclk), 1);
        #4;
        chk("R9 dclk low", 32'(dclk), 0);
        @(posedge clk); #1; rst_n = 1'b1;
    endtask

    task automatic t_offset;   // R1 code 0
        c_rfmt = 2'd0; run("R1 offset", 30, 1);
    endtask

    task automatic t_twos;     // R1 code 1
        c_rfmt = 2'd1; run("R1 twos", 30, 2);
    endtask

    task automatic t_gray;     // R1 code 2 and spare code 3
        c_rfmt = 2'd2; run("R1 gray", 30, 3);
        c_rfmt = 2'd3; run("R1 spare", 20, 4);
    endtask

    task automatic t_ddr;      // R3 R5 double-rate with Gray then twos
        c_rddr = 1'b1; c_rfmt = 2'd2; run("R3 ddr gray", 30, 5);
        c_rfmt = 2'd1; run("R3 ddr twos", 20, 6);
    endtask

    task automatic t_switch;   // R8 per-sample changes of coding and mode
        for (int k = 0; k < 40; k++) begin
            c_rfmt = 2'(k % 3);
            c_rddr = 1'((k / 3) % 2);
            tick("R8 switch", 14'((k * 4099 + 77) & 16'h3fff), 1'(k % 2));
        end
        c_rddr = 1'b0;
        run("R8 settle", LAT + 2, 7);
    endtask

    task automatic t_oe;       // R6 blanking both modes, pipeline keeps going
        c_rfmt = 2'd0;
        for (int k = 0; k < 40; k++) begin
            c_oe_n = 1'((k / 5) % 2);
            c_rddr = 1'(k >= 20);
            tick("R6 oe", 14'((k * 611 + 5) & 16'h3fff), 1'b1);
        end
        c_oe_n = 1'b0;
        run("R6 reenable", LAT + 2, 8);
    endtask

    task automatic t_strap;    // R7 straps override registers
        c_sen = 1'b1; c_rfmt = 2'd2; c_rddr = 1'b1;
        c_sfmt = 1'b1; c_sddr = 1'b0; run("R7 strap twos sdr", 25, 9);
        c_sfmt = 1'b0; c_sddr = 1'b1; run("R7 strap offset ddr", 25, 10);
        c_sen = 1'b0;  run("R7 strap off", LAT + 4, 11);
    endtask

    initial begin
        for (int k = 0; k < 4096; k++) begin
            h_word[k] = '0; h_ovr[k] = 1'b0; h_ddr[k] = 1'b0;
        end
        t_reset;
        t_offset;
        t_twos;
        t_gray;
        t_ddr;
        t_switch;
        t_oe;
        t_strap;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule